// File: doc/BRIEF.md
# Prescaled Output-Compare Timer

A timer peripheral built around one 16-bit up-counter that steps once every P system clocks. P is a power of two picked by a configuration register. Several compare channels watch the counter. Each raises its own flag when the counter arrives at that channel's programmed value. The counter raises an overflow flag when it wraps to zero. A separate divider raises a periodic tick flag at a programmable interval. Each flag has an enable bit, and the enabled flags are ORed into one interrupt request.

Software reaches the block through a plain byte-wide register port. This port has no valid/ready handshake: a write lands on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`.

Register addresses (decimal), with each 16-bit value stored high byte first:

| Address | Contents |
| --- | --- |
| 0 | Counter high byte |
| 1 | Counter low byte, as latched |
| 2 + 2k, 3 + 2k | Compare channel k+1, high and low byte (k = 0 to 4) |
| 12 | Compare flags |
| 13 | Compare enables |
| 14 | Timer flags |
| 15 | Timer enables |
| 16 | Prescale select, bits 1:0 |
| 17 | Tick period select, bits 1:0 |

Top module: `ptimer_oc`

## Requirements
- R1: While reset is held and right after it is released, the following registers read 0x00: counter high and low bytes, both flag registers, both enable registers and prescale select. All compare bytes read 0xFF.
- R2: With prescale select s, the counter increments by exactly one every 2^s clocks. Over 400 clocks at s=2 it advances by 100, and over 100 clocks at s=0 it also advances by 100.
- R3: Bit 7 of address 14 (overflow flag) is set on the edge where the counter steps from 0xFFFF to 0x0000.
- R4: The flag of compare channel k (k = 1 to 5) is bit 8-k of address 12, so channel 1 is bit 7 and channel 5 is bit 3. The flag is set on the edge where the counter steps onto that channel's compare value, including values reached only after the counter wraps through zero.
- R5: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. If a clear and a set hit the same edge, the flag ends up set.
- R6: `irq` is high exactly when some flag is set and its enable bit is also set. Enable bits sit at the same positions as their flags: bits 7:3 of address 13, and bits 7:6 of address 15. Bits that have no flag read back as 0.
- R7: Bit 6 of address 14 (tick flag) is set every 2^(4+t) clocks, where t is the tick period select. The interval runs from the previous tick, not from when software cleared the flag.
- R8: Reading address 0 with `bus_rd` high stores the counter low byte of that same cycle. Address 1 returns this stored byte, so a later read of it gives a value coherent with the high byte.
- R9: Each compare byte is written and read back at its own address, high byte at the even address and low byte at the following address. Writing one byte leaves the other byte of the pair unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used only to latch the counter low byte) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench places compare values a known number of counter steps ahead of a freshly read counter value. It then samples the flag one clock before and one clock after the predicted edge, which separates a correct match from matches that fire early, late or on the wrong bit. A second pattern sets compare values just below 0xFFFF and just above 0x0000 and lets the counter wrap. This catches a missed wraparound match and checks that the overflow flag is set exactly when the counter reads zero. Two further patterns are used: a clear timed onto the match edge checks set priority, and a clear issued between periodic ticks checks that the tick interval is independent of software.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 5'd0;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 5'd1;
  localparam int                CMP_BASE = 2;
  localparam logic [ADDR_W-1:0] A_FLAG1  = 5'd12;
  localparam logic [ADDR_W-1:0] A_MASK1  = 5'd13;
  localparam logic [ADDR_W-1:0] A_FLAG2  = 5'd14;
  localparam logic [ADDR_W-1:0] A_MASK2  = 5'd15;
  localparam logic [ADDR_W-1:0] A_PRESC  = 5'd16;
  localparam logic [ADDR_W-1:0] A_RTICFG = 5'd17;
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DIV_W'(1);
  end

  // tick when all low 'sel' bits of the free-running divider are ones
  always_comb begin
    tick = 1'b1;
    for (int b = 0; b < DIV_W; b++)
      if (b < int'(sel)) tick = tick & div_q[b];
  end
endmodule

// File: rtl/timer_rti.sv
module timer_rti #(
  parameter int BASE  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int RW = BASE + (1 << SEL_W) - 1;

  logic [RW-1:0] per_q;
  logic [RW-1:0] last;

  always_comb begin
    last = '0;
    for (int b = 0; b < RW; b++)
      if (b < BASE + int'(sel)) last[b] = 1'b1;
  end

  assign tick = (per_q >= last);

  // restarts only on its own tick, never on software activity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    per_q <= '0;
    else if (tick) per_q <= '0;
    else           per_q <= per_q + RW'(1);
  end
endmodule

// File: rtl/timer_cmp_bank.sv
module timer_cmp_bank
  import timer_pkg::*;
#(
  parameter int N  = 5,
  parameter int CW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  input  logic                  adv,
  input  logic [CW-1:0]         cnt_nxt,
  output logic [N-1:0][CW-1:0]  cmp_o,
  output logic [N-1:0]          hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(CMP_BASE + 2 * i);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(CMP_BASE + 2 * i + 1);
    logic [CW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 val_q <= '1;
      else if (wr && addr == HI)  val_q[CW-1:8] <= wdata;
      else if (wr && addr == LO)  val_q[7:0]    <= wdata;
    end

    assign cmp_o[i] = val_q;
    // counter steps one value at a time, so arrival covers wraparound too
    assign hit_o[i] = adv && (cnt_nxt == val_q);
  end
endmodule

// File: rtl/ptimer_oc.sv
module ptimer_oc
  import timer_pkg::*;
#(
  parameter int N_CMP     = 5,
  parameter int PRE_SEL_W = 2,
  parameter int RTI_BASE  = 4,
  parameter int RTI_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int         CW      = 16;
  localparam logic [7:0] F1_LIVE = 8'(((1 << N_CMP) - 1) << (8 - N_CMP));
  localparam logic [7:0] F2_LIVE = 8'hC0;

  logic                      adv, rti_tick;
  logic [CW-1:0]             cnt_q, cnt_nxt;
  logic [7:0]                lo_hold_q, flag1_q, flag2_q, mask1_q, mask2_q;
  logic [7:0]                set1, set2, rdata_c;
  logic [PRE_SEL_W-1:0]      presc_q;
  logic [RTI_SEL_W-1:0]      rti_sel_q;
  logic [N_CMP-1:0]          hit;
  logic [N_CMP-1:0][CW-1:0]  cmp_all;

  assign cnt_nxt = cnt_q + CW'(1);

  timer_prescale #(.SEL_W(PRE_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(presc_q), .tick(adv));

  timer_rti #(.BASE(RTI_BASE), .SEL_W(RTI_SEL_W)) u_rti (
    .clk(clk), .rst_n(rst_n), .sel(rti_sel_q), .tick(rti_tick));

  timer_cmp_bank #(.N(N_CMP), .CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .adv(adv), .cnt_nxt(cnt_nxt), .cmp_o(cmp_all), .hit_o(hit));

  // channel 1 lands on bit 7, later channels one bit lower each
  always_comb begin
    set1 = '0;
    for (int i = 0; i < N_CMP; i++) set1[7-i] = hit[i];
  end

  assign set2 = {adv && (cnt_q == '1), rti_tick, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lo_hold_q <= '0;
      flag1_q   <= '0;
      flag2_q   <= '0;
      mask1_q   <= '0;
      mask2_q   <= '0;
      presc_q   <= '0;
      rti_sel_q <= '0;
    end else begin
      if (adv) cnt_q <= cnt_nxt;
      if (bus_rd && bus_addr == A_CNT_H) lo_hold_q <= cnt_q[7:0];
      // set term ORed last: a same-edge set beats the clear
      flag1_q <= ((bus_wr && bus_addr == A_FLAG1) ? (flag1_q & ~bus_wdata) : flag1_q) | set1;
      flag2_q <= ((bus_wr && bus_addr == A_FLAG2) ? (flag2_q & ~bus_wdata) : flag2_q) | set2;
      if (bus_wr) begin
        case (bus_addr)
          A_MASK1:  mask1_q   <= bus_wdata & F1_LIVE;
          A_MASK2:  mask2_q   <= bus_wdata & F2_LIVE;
          A_PRESC:  presc_q   <= bus_wdata[PRE_SEL_W-1:0];
          A_RTICFG: rti_sel_q <= bus_wdata[RTI_SEL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_c = '0;
    case (bus_addr)
      A_CNT_H:  rdata_c = cnt_q[CW-1:8];
      A_CNT_L:  rdata_c = lo_hold_q;
      A_FLAG1:  rdata_c = flag1_q;
      A_MASK1:  rdata_c = mask1_q;
      A_FLAG2:  rdata_c = flag2_q;
      A_MASK2:  rdata_c = mask2_q;
      A_PRESC:  rdata_c[PRE_SEL_W-1:0] = presc_q;
      A_RTICFG: rdata_c[RTI_SEL_W-1:0] = rti_sel_q;
      default: begin
        for (int i = 0; i < N_CMP; i++) begin
          if (bus_addr == ADDR_W'(CMP_BASE + 2 * i))     rdata_c = cmp_all[i][CW-1:8];
          if (bus_addr == ADDR_W'(CMP_BASE + 2 * i + 1)) rdata_c = cmp_all[i][7:0];
        end
      end
    endcase
  end

  assign bus_rdata = rdata_c;
  assign irq = (|(flag1_q & mask1_q)) | (|(flag2_q & mask2_q));
endmodule

// File: rtl/ptimer_oc_chk.sv
module ptimer_oc_chk
  import timer_pkg::*;
#(
  parameter int N_CMP = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [7:0]              bus_wdata,
  input logic                    irq,
  input logic [15:0]             cnt,
  input logic [7:0]              flag1,
  input logic                    tof,
  input logic [7:0]              mask1,
  input logic [7:0]              mask2,
  input logic [N_CMP-1:0][15:0]  cmp
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> cnt == $past(cnt) + 16'd1);

  // R3
  tof_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tof) |-> cnt == 16'h0000);

  for (genvar i = 0; i < N_CMP; i++) begin : g_hit
    // R4
    cmp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag1[7-i]) |-> cnt == $past(cmp[i]));
  end

  // R5
  keep_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FLAG1 && bus_wdata == 8'h00)
      |=> ((flag1 & $past(flag1)) == $past(flag1)));

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask1 == 8'h00 && mask2 == 8'h00) |-> !irq);
endmodule

bind ptimer_oc ptimer_oc_chk #(.N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .cnt(cnt_q), .flag1(flag1_q),
  .tof(flag2_q[7]), .mask1(mask1_q), .mask2(mask2_q), .cmp(cmp_all));

// File: tb/tb_ptimer_oc.sv
`timescale 1ns/1ps
module tb_ptimer_oc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0, fails = 0, cyc = 0, last_edge = 0;

  ptimer_oc dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {check, write, addr, data, expect}
  localparam int NV = 22;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd12, 8'h00, 8'h00}, {1'b1, 1'b0, 5'd13, 8'h00, 8'h00},
    {1'b1, 1'b0, 5'd15, 8'h00, 8'h00}, {1'b1, 1'b0, 5'd2,  8'h00, 8'hFF},
    {1'b1, 1'b0, 5'd3,  8'h00, 8'hFF}, {1'b1, 1'b0, 5'd10, 8'h00, 8'hFF},
    {1'b1, 1'b0, 5'd11, 8'h00, 8'hFF}, {1'b1, 1'b0, 5'd16, 8'h00, 8'h00},
    {1'b0, 1'b1, 5'd4,  8'h12, 8'h00}, {1'b0, 1'b1, 5'd5,  8'h34, 8'h00},
    {1'b1, 1'b0, 5'd4,  8'h00, 8'h12}, {1'b1, 1'b0, 5'd5,  8'h00, 8'h34},
    {1'b0, 1'b1, 5'd9,  8'hAB, 8'h00}, {1'b1, 1'b0, 5'd8,  8'h00, 8'hFF},
    {1'b1, 1'b0, 5'd9,  8'h00, 8'hAB}, {1'b0, 1'b1, 5'd13, 8'hFF, 8'h00},
    {1'b1, 1'b0, 5'd13, 8'h00, 8'hF8}, {1'b0, 1'b1, 5'd13, 8'h00, 8'h00},
    {1'b0, 1'b1, 5'd15, 8'hFF, 8'h00}, {1'b1, 1'b0, 5'd15, 8'h00, 8'hC0},
    {1'b0, 1'b1, 5'd15, 8'h00, 8'h00}, {1'b1, 1'b0, 5'd17, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [4:0] a, input logic [7:0] d,
                    output logic [7:0] q);
    @(negedge clk);
    bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d;
    #1 q = bus_rdata;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_rd = 1'b0; last_edge = cyc;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] q;
    op(1'b1, a, d, q);
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] q);
    bus_addr = a;
    #1 q = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v, output int e);
    logic [7:0] h, l;
    op(1'b0, 5'd0, 8'h00, h);
    e = last_edge;
    op(1'b0, 5'd1, 8'h00, l);
    v = {h, l};
  endtask

  task automatic wait_edge(input int t);
    while (cyc < t) begin @(posedge clk); #1; end
  endtask

  task automatic poll(input logic [4:0] a, input logic [7:0] m, input int lim,
                      output int at);
    logic [7:0] q;
    at = -1;
    for (int k = 0; k < lim && at < 0; k++) begin
      @(posedge clk); #1;
      peek(a, q);
      if ((q & m) != 0) at = cyc;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    logic [15:0] a, b, c;
    int e, e2, t0, t1, t2;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    peek(5'd0, q);  check("R1 cnt hi in reset", {8'h0, q}, 16'h0);
    peek(5'd1, q);  check("R1 cnt lo in reset", {8'h0, q}, 16'h0);
    peek(5'd14, q); check("R1 flag2 in reset", {8'h0, q}, 16'h0);
    peek(5'd12, q); check("R1 flag1 in reset", {8'h0, q}, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R9 vector table
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][21], VEC[i][20:16], VEC[i][15:8], q);
      if (VEC[i][22]) check(i < 8 ? "R1 table" : "R9 table", {8'h0, q}, {8'h0, VEC[i][7:0]});
    end

    // R2: prescale 4 and 1
    wr(5'd16, 8'd2);
    rd_cnt(a, e); repeat (398) @(posedge clk); rd_cnt(b, e2);
    check("R2 prescale 4", b - a, 16'd100);
    wr(5'd16, 8'd0);
    rd_cnt(a, e); repeat (98) @(posedge clk); rd_cnt(b, e2);
    check("R2 prescale 1", b - a, 16'd100);

    // R8: delayed low-byte read stays coherent
    op(1'b0, 5'd0, 8'h00, q); a[15:8] = q;
    repeat (300) @(posedge clk);
    op(1'b0, 5'd1, 8'h00, q); a[7:0] = q;
    rd_cnt(b, e);
    check("R8 latched low byte", b - a, 16'd302);

    // R4: channel 3 (bit 5) fires on the exact arrival edge
    rd_cnt(c, e);
    wr(5'd6, 8'((c + 16'd60) >> 8));
    wr(5'd7, 8'(c + 16'd60));
    wr(5'd12, 8'hF8);
    wait_edge(e + 58); peek(5'd12, q);
    check("R4 ch3 before match", {8'h0, q & 8'h20}, 16'h00);
    wait_edge(e + 59); peek(5'd12, q);
    check("R4 ch3 at match", {8'h0, q & 8'h20}, 16'h20);

    // R6: irq follows flag & enable
    wr(5'd13, 8'h20); #1;
    check("R6 irq enabled", {15'h0, irq}, 16'h1);
    wr(5'd13, 8'h00); #1;
    check("R6 irq masked", {15'h0, irq}, 16'h0);

    // R5: write zero keeps, write one clears
    wr(5'd12, 8'h00); peek(5'd12, q);
    check("R5 write zero keeps", {8'h0, q & 8'h20}, 16'h20);
    wr(5'd12, 8'h20); peek(5'd12, q);
    check("R5 write one clears", {8'h0, q & 8'h20}, 16'h00);

    // R5: clear on the match edge of channel 2 (bit 6) loses to the set
    rd_cnt(c, e);
    wr(5'd4, 8'((c + 16'd40) >> 8));
    wr(5'd5, 8'(c + 16'd40));
    wr(5'd12, 8'h40);
    wait_edge(e + 38);
    wr(5'd12, 8'h40);
    peek(5'd12, q);
    check("R5 set wins over clear", {8'h0, q & 8'h40}, 16'h40);

    // R3 + R4 wrap: ch1 near top, ch5 just past zero
    wr(5'd2, 8'hFF); wr(5'd3, 8'hFE);
    wr(5'd10, 8'h00); wr(5'd11, 8'h03);
    wr(5'd12, 8'hF8); wr(5'd14, 8'hC0);
    poll(5'd14, 8'h80, 70000, t0);
    check("R3 overflow seen", {15'h0, t0 >= 0}, 16'h1);
    peek(5'd12, q);
    check("R4 ch1 set, ch5 not yet", {8'h0, q & 8'h88}, 16'h80);
    rd_cnt(a, e);
    check("R3 counter zero at overflow", a, 16'h0000);
    repeat (5) @(posedge clk); #1;
    peek(5'd12, q);
    check("R4 ch5 after wrap", {8'h0, q & 8'h88}, 16'h88);
    wr(5'd15, 8'h80); #1;
    check("R6 irq from overflow", {15'h0, irq}, 16'h1);
    wr(5'd14, 8'h80); #1;
    check("R6 irq after overflow clear", {15'h0, irq}, 16'h0);
    wr(5'd15, 8'h00);

    // R7: tick spacing ignores the clear time
    wr(5'd17, 8'd0); wr(5'd14, 8'h40);
    poll(5'd14, 8'h40, 300, t0); wr(5'd14, 8'h40);
    poll(5'd14, 8'h40, 300, t1); wr(5'd14, 8'h40);
    poll(5'd14, 8'h40, 300, t2);
    check("R7 period 16", 16'(t2 - t1), 16'd16);
    wr(5'd17, 8'd1); wr(5'd14, 8'h40);
    poll(5'd14, 8'h40, 300, t0); wr(5'd14, 8'h40);
    poll(5'd14, 8'h40, 300, t1); wr(5'd14, 8'h40);
    poll(5'd14, 8'h40, 300, t2);
    check("R7 period 32", 16'(t2 - t1), 16'd32);

    finish_run();
  end
endmodule